// File: doc/BRIEF.md
# Reset Sequencer with Pin Glitch Filter

This block sequences the resets of a microcontroller. It watches an asynchronous external reset pin, synchronizes it, measures how long each assertion lasts, and sorts each assertion into one of three kinds. A very short blip is ignored. A medium-length pulse is recorded as a glitch and does not reset anything. A long pulse is a real external reset.

A real external reset, an enabled checkstop input or a software system-reset request starts a full internal reset. During a full reset the block drives both the internal reset line and the reset-out pin for a fixed number of clocks. Software can also request a reset-out pulse alone, which leaves the internal logic running, and can cut that pulse short. Each time reset-out negates, the block samples the boot-configuration and weak-pull pins and holds their values as read-only status.

The block records the cause of the last reset in sticky flags. Software reads and clears those flags, and controls the block, through a small register port with a combinational read path. The synchronous power-on reset starts a full reset sequence of its own.

Top module: `rst_sequencer`

## Requirements
- R1: A reset-pin assertion that lasts 3 to 9 consecutive synchronized clocks (more than 2, fewer than 10) sets the glitch flag, bit 5 of the status register at address 0, and does not start a reset.
- R2: A reset-pin assertion that lasts 10 or more consecutive synchronized clocks starts a full reset. That sets sys_rst_o and rst_out_o and sets the pin-cause flag, status bit 1. An assertion of 2 clocks or fewer has no effect.
- R3: The glitch flag is cleared by a valid pin reset, by power-on reset, or by writing 1 to status bit 5.
- R4: Writing 1 to bit 0 of the control register at address 1, while no pulse runs, raises sys_rst_o and rst_out_o together for exactly RST_LEN clocks. It also sets the software-system flag, status bit 3, and clears the other cause flags in status bits 0 to 4.
- R5: Writing 1 to control bit 1 while idle raises rst_out_o alone for exactly RST_LEN clocks, with sys_rst_o low. It sets status bit 4. Control bit 1 reads 1 while this pulse runs and 0 after it ends.
- R6: A software request, from control bit 0 or bit 1, made while a pulse is already running is ignored, and the running pulse keeps its original length.
- R7: Writing 0 to control bit 1 while a software-only pulse runs drops rst_out_o on the next clock.
- R8: The checkstop input starts a full reset and sets status bit 2 only while control bit 2 is 1. Control bit 2 is 1 after power-on reset.
- R9: On each falling edge of rst_out_o, boot_cfg_i is captured into bits 1:0 of address 2 and pull_cfg_i into status bit 6. These values do not change at any other time, and writes do not affect them.
- R10: While rst_n is low, sys_rst_o and rst_out_o are high. They stay high for RST_LEN clocks after rst_n rises. After power-on the cause flags read 0x01 (power-on flag, status bit 0).
- R11: Writing 1 to a cause flag in status bits 0 to 4 clears that flag and leaves the other flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| pin_rst_i | input | 1 | External reset pin, active high, asynchronous |
| chkstop_i | input | 1 | Checkstop reset request, active high |
| boot_cfg_i | input | 2 | Boot-configuration pins |
| pull_cfg_i | input | 1 | Weak-pull configuration pin |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address: 0 status, 1 control, 2 configuration |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational from reg_addr_i |
| sys_rst_o | output | 1 | Internal system reset, active high |
| rst_out_o | output | 1 | Reset-out pin drive, active high |

## Verification
A fault in the pin length counter shows up within about 12 clocks of the pin's release. The glitch and pin-cause flags then read wrong, or sys_rst_o rises when it should not, so the bench sweeps pulse lengths across both thresholds. A fault in the sequencer state or its down-counter changes how many cycles the reset lines stay high, or their pairing, on the very first pulse. The bench therefore counts each pulse edge to edge. Faults in the flag and capture registers stay hidden until the next read, so every stimulus is followed by a register read.

// File: rtl/rst_seq_pkg.sv
// Package: shared types and register layout for the reset sequencer.
// Assumes an 8-bit register port with a 2-bit address.
package rst_seq_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_SYS  = 2'd1,
        SEQ_EXT  = 2'd2
    } seq_state_e;

    localparam int REG_AW = 2;
    localparam int REG_DW = 8;

    localparam logic [REG_AW-1:0] ADDR_STATUS = 2'd0;
    localparam logic [REG_AW-1:0] ADDR_CTRL   = 2'd1;
    localparam logic [REG_AW-1:0] ADDR_CFG    = 2'd2;

    // Status bit positions
    localparam int ST_POR   = 0;
    localparam int ST_PIN   = 1;
    localparam int ST_CHK   = 2;
    localparam int ST_SWS   = 3;
    localparam int ST_SWE   = 4;
    localparam int ST_GLT   = 5;
    localparam int ST_PULL  = 6;
    localparam int N_FLAGS  = 6;
    localparam int N_CAUSES = 5;

    // Control bit positions
    localparam int CT_SYS   = 0;
    localparam int CT_EXT   = 1;
    localparam int CT_CHKEN = 2;

endpackage

// File: rtl/rst_pin_filter.sv
// Reset pin filter: synchronizes the asynchronous reset pin and measures
// each assertion with a saturating counter. It flags a glitch when the pin
// drops after more than GLITCH_MIN and fewer than VALID_LEN high cycles,
// and a valid reset on the VALID_LEN-th consecutive high cycle.
// Assumes GLITCH_MIN < VALID_LEN and SYNC_STAGES >= 1.
module rst_pin_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int GLITCH_MIN  = 2,
    parameter int VALID_LEN   = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic valid_evt_o,
    output logic glitch_evt_o
);
    localparam int CNT_W = $clog2(VALID_LEN + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   pin_s;
    logic [CNT_W-1:0]       len_q;

    generate
        if (SYNC_STAGES == 1) begin : g_sync1
            // Single-stage capture of the pin
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= pin_i;
            end
        end else begin : g_syncn
            // Multi-stage synchronizer shift chain
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
            end
        end
    endgenerate

    assign pin_s = sync_q[SYNC_STAGES-1];

    // Saturating count of consecutive synchronized high cycles
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q <= '0;
        end else if (pin_s) begin
            if (len_q != CNT_W'(VALID_LEN)) len_q <= len_q + 1'b1;
        end else begin
            len_q <= '0;
        end
    end

    // Classify the current cycle
    always_comb begin
        valid_evt_o  = pin_s && (len_q == CNT_W'(VALID_LEN - 1));
        glitch_evt_o = !pin_s && (len_q > CNT_W'(GLITCH_MIN))
                              && (len_q < CNT_W'(VALID_LEN));
    end

endmodule

// File: rtl/rst_seq_fsm.sv
// Reset sequencer state machine: runs a full reset (internal reset and
// reset-out) or a software-only reset-out pulse of RST_LEN clocks.
// Hardware events restart into a full reset unless one is running.
// Software requests are taken only when idle. A software-only pulse can
// be cancelled. Power-on reset enters the full-reset state.
// Assumes RST_LEN >= 2.
module rst_seq_fsm
    import rst_seq_pkg::*;
#(
    parameter int RST_LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hw_evt_i,
    input  logic sw_sys_i,
    input  logic sw_ext_set_i,
    input  logic sw_ext_clr_i,
    output logic sys_rst_o,
    output logic rst_out_o,
    output logic sys_start_o,
    output logic sw_sys_taken_o,
    output logic ext_start_o,
    output logic ext_busy_o,
    output logic done_o
);
    localparam int CNT_W = $clog2(RST_LEN + 1);

    seq_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             ext_cancel;

    // Request arbitration and next-state selection
    always_comb begin
        sys_start_o    = (state_q != SEQ_SYS) &&
                         (hw_evt_i || (sw_sys_i && state_q == SEQ_IDLE));
        sw_sys_taken_o = sw_sys_i && (state_q == SEQ_IDLE);
        ext_start_o    = (state_q == SEQ_IDLE) && sw_ext_set_i && !sys_start_o;
        ext_cancel     = (state_q == SEQ_EXT) && sw_ext_clr_i && !sys_start_o;
        state_d        = state_q;
        if (sys_start_o)                                state_d = SEQ_SYS;
        else if (ext_start_o)                           state_d = SEQ_EXT;
        else if (ext_cancel)                            state_d = SEQ_IDLE;
        else if (state_q != SEQ_IDLE && cnt_q == '0)    state_d = SEQ_IDLE;
    end

    // State register, power-on enters a full reset
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEQ_SYS;
        else        state_q <= state_d;
    end

    // Pulse down-counter, loaded on each accepted start
    always_ff @(posedge clk) begin
        if (!rst_n)                              cnt_q <= CNT_W'(RST_LEN - 1);
        else if (sys_start_o || ext_start_o)     cnt_q <= CNT_W'(RST_LEN - 1);
        else if (state_q != SEQ_IDLE && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    // Output decode from the state register
    always_comb begin
        sys_rst_o  = (state_q == SEQ_SYS);
        rst_out_o  = (state_q != SEQ_IDLE);
        ext_busy_o = (state_q == SEQ_EXT);
        done_o     = (state_q != SEQ_IDLE) && (state_d == SEQ_IDLE);
    end

endmodule

// File: rtl/rst_seq_regs.sv
// Register file of the reset sequencer: sticky cause flags with
// write-one-to-clear, control bits, and the configuration pins captured
// when reset-out negates. Reads are combinational from the address.
// Assumes event inputs are single-cycle pulses from the sequencer.
module rst_seq_regs
    import rst_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_i,
    input  logic [REG_AW-1:0] reg_addr_i,
    input  logic [REG_DW-1:0] reg_wdata_i,
    output logic [REG_DW-1:0] reg_rdata_o,
    input  logic              valid_evt_i,
    input  logic              glitch_evt_i,
    input  logic              sys_start_i,
    input  logic              pin_cause_i,
    input  logic              chk_cause_i,
    input  logic              sws_cause_i,
    input  logic              swe_cause_i,
    input  logic              done_i,
    input  logic              ext_busy_i,
    input  logic [1:0]        boot_cfg_i,
    input  logic              pull_cfg_i,
    output logic              sw_sys_o,
    output logic              sw_ext_set_o,
    output logic              sw_ext_clr_o,
    output logic              chk_en_o
);
    logic [N_FLAGS-1:0] flags_q, flags_d;
    logic [N_FLAGS-1:0] cause_set;
    logic               chk_en_q;
    logic [1:0]         boot_q;
    logic               pull_q;
    logic               wr_status, wr_ctrl;
    logic               unused_wdata;

    assign wr_status    = reg_wr_i && (reg_addr_i == ADDR_STATUS);
    assign wr_ctrl      = reg_wr_i && (reg_addr_i == ADDR_CTRL);
    assign sw_sys_o     = wr_ctrl && reg_wdata_i[CT_SYS];
    assign sw_ext_set_o = wr_ctrl && reg_wdata_i[CT_EXT];
    assign sw_ext_clr_o = wr_ctrl && !reg_wdata_i[CT_EXT];
    assign chk_en_o     = chk_en_q;
    assign unused_wdata = ^reg_wdata_i[REG_DW-1:N_FLAGS];

    // Collect the cause-setting pulses into flag positions
    always_comb begin
        cause_set          = '0;
        cause_set[ST_PIN]  = pin_cause_i;
        cause_set[ST_CHK]  = chk_cause_i;
        cause_set[ST_SWS]  = sws_cause_i;
        cause_set[ST_SWE]  = swe_cause_i;
    end

    // Flag update: clear on write, a new system reset replaces the causes
    always_comb begin
        flags_d = flags_q;
        if (wr_status) flags_d = flags_d & ~reg_wdata_i[N_FLAGS-1:0];
        for (int i = 0; i < N_CAUSES; i++) begin
            if (sys_start_i)  flags_d[i] = 1'b0;
            if (cause_set[i]) flags_d[i] = 1'b1;
        end
        if (valid_evt_i)  flags_d[ST_GLT] = 1'b0;
        if (glitch_evt_i) flags_d[ST_GLT] = 1'b1;
    end

    // Flag register, power-on leaves only the power-on flag
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= N_FLAGS'(1) << ST_POR;
        else        flags_q <= flags_d;
    end

    // Checkstop enable control bit, enabled out of power-on
    always_ff @(posedge clk) begin
        if (!rst_n)       chk_en_q <= 1'b1;
        else if (wr_ctrl) chk_en_q <= reg_wdata_i[CT_CHKEN];
    end

    // Configuration pin capture at the negation of reset-out
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            boot_q <= '0;
            pull_q <= 1'b0;
        end else if (done_i) begin
            boot_q <= boot_cfg_i;
            pull_q <= pull_cfg_i;
        end
    end

    // Read multiplexer
    always_comb begin
        reg_rdata_o = '0;
        case (reg_addr_i)
            ADDR_STATUS: begin
                reg_rdata_o[N_FLAGS-1:0] = flags_q;
                reg_rdata_o[ST_PULL]     = pull_q;
            end
            ADDR_CTRL: begin
                reg_rdata_o[CT_EXT]   = ext_busy_i;
                reg_rdata_o[CT_CHKEN] = chk_en_q;
            end
            ADDR_CFG:  reg_rdata_o[1:0] = boot_q;
            default:   reg_rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/rst_sequencer.sv
// Top of the reset sequencer: pin filter, sequencer state machine and
// register file. Combines the hardware reset sources and routes cause
// pulses to the flags. Assumes rst_n is a synchronous power-on reset.
module rst_sequencer
    import rst_seq_pkg::*;
#(
    parameter int RST_LEN     = 16,
    parameter int GLITCH_MIN  = 2,
    parameter int VALID_LEN   = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pin_rst_i,
    input  logic              chkstop_i,
    input  logic [1:0]        boot_cfg_i,
    input  logic              pull_cfg_i,
    input  logic              reg_wr_i,
    input  logic [REG_AW-1:0] reg_addr_i,
    input  logic [REG_DW-1:0] reg_wdata_i,
    output logic [REG_DW-1:0] reg_rdata_o,
    output logic              sys_rst_o,
    output logic              rst_out_o
);
    logic valid_evt, glitch_evt, hw_evt, chk_evt;
    logic sw_sys_req, sw_ext_set, sw_ext_clr, chk_en;
    logic sys_start, sw_sys_taken, ext_start, ext_busy, seq_done;

    // Hardware reset sources
    assign chk_evt = chkstop_i && chk_en;
    assign hw_evt  = valid_evt || chk_evt;

    rst_pin_filter #(
        .SYNC_STAGES (SYNC_STAGES),
        .GLITCH_MIN  (GLITCH_MIN),
        .VALID_LEN   (VALID_LEN)
    ) u_filter (
        .clk          (clk),
        .rst_n        (rst_n),
        .pin_i        (pin_rst_i),
        .valid_evt_o  (valid_evt),
        .glitch_evt_o (glitch_evt)
    );

    rst_seq_fsm #(
        .RST_LEN (RST_LEN)
    ) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .hw_evt_i       (hw_evt),
        .sw_sys_i       (sw_sys_req),
        .sw_ext_set_i   (sw_ext_set),
        .sw_ext_clr_i   (sw_ext_clr),
        .sys_rst_o      (sys_rst_o),
        .rst_out_o      (rst_out_o),
        .sys_start_o    (sys_start),
        .sw_sys_taken_o (sw_sys_taken),
        .ext_start_o    (ext_start),
        .ext_busy_o     (ext_busy),
        .done_o         (seq_done)
    );

    rst_seq_regs u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_wr_i     (reg_wr_i),
        .reg_addr_i   (reg_addr_i),
        .reg_wdata_i  (reg_wdata_i),
        .reg_rdata_o  (reg_rdata_o),
        .valid_evt_i  (valid_evt),
        .glitch_evt_i (glitch_evt),
        .sys_start_i  (sys_start),
        .pin_cause_i  (sys_start && valid_evt),
        .chk_cause_i  (sys_start && chk_evt),
        .sws_cause_i  (sw_sys_taken),
        .swe_cause_i  (ext_start),
        .done_i       (seq_done),
        .ext_busy_i   (ext_busy),
        .boot_cfg_i   (boot_cfg_i),
        .pull_cfg_i   (pull_cfg_i),
        .sw_sys_o     (sw_sys_req),
        .sw_ext_set_o (sw_ext_set),
        .sw_ext_clr_o (sw_ext_clr),
        .chk_en_o     (chk_en)
    );

endmodule

// File: rtl/rst_seq_chk.sv
// Checker for the reset sequencer, bound to the top module. It relates
// the filter events, request strobes and outputs over time, and bounds
// the length of each full reset with a run counter.
module rst_seq_chk #(
    parameter int RST_LEN = 16
) (
    input logic       clk,
    input logic       rst_n,
    input logic       sys_rst,
    input logic       rst_out,
    input logic       valid_evt,
    input logic       glitch_evt,
    input logic       hw_evt,
    input logic       chkstop,
    input logic       chk_en,
    input logic       sw_sys,
    input logic       ext_clr,
    input logic [1:0] reg_addr,
    input logic [7:0] reg_rdata
);
    int unsigned run_q;

    // Length of the current full-reset run
    always_ff @(posedge clk) begin
        if (!rst_n)       run_q <= 0;
        else if (sys_rst) run_q <= run_q + 1;
        else              run_q <= 0;
    end

    AST_SYS_WITH_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst |-> rst_out);  // R4

    AST_SYS_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= RST_LEN);  // R4

    AST_VALID_STARTS_SYS: assert property (@(posedge clk) disable iff (!rst_n)
        valid_evt && !sys_rst |=> sys_rst);  // R2

    AST_GLITCH_NO_SYS: assert property (@(posedge clk) disable iff (!rst_n)
        glitch_evt && !sys_rst && !hw_evt && !sw_sys |=> !sys_rst);  // R1

    AST_EXT_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
        ext_clr && rst_out && !sys_rst && !hw_evt |=> !rst_out);  // R7

    AST_CHK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        chkstop && !chk_en && !valid_evt && !sw_sys && !sys_rst |=> !sys_rst);  // R8

    AST_CFG_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 2'd2) && ($past(reg_addr) == 2'd2) && !rst_out && !$past(rst_out)
        |-> $stable(reg_rdata));  // R9

endmodule

bind rst_sequencer rst_seq_chk #(.RST_LEN(RST_LEN)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sys_rst    (sys_rst_o),
    .rst_out    (rst_out_o),
    .valid_evt  (valid_evt),
    .glitch_evt (glitch_evt),
    .hw_evt     (hw_evt),
    .chkstop    (chkstop_i),
    .chk_en     (chk_en),
    .sw_sys     (sw_sys_req),
    .ext_clr    (sw_ext_clr),
    .reg_addr   (reg_addr_i),
    .reg_rdata  (reg_rdata_o)
);

// File: tb/test_rst_sequencer.sv
// Bench for the reset sequencer: a table of pin pulse lengths walked by
// one loop, then directed tests for software requests, checkstop, capture
// and power-on reset.
module test_rst_sequencer;
    localparam int RST_LEN = 16;
    localparam int NVEC    = 8;
    localparam int VEC_LEN [NVEC] = '{1, 2, 3, 5, 9, 10, 11, 14};
    localparam bit VEC_GLT [NVEC] = '{0, 0, 1, 1, 1, 0, 0, 0};
    localparam bit VEC_RST [NVEC] = '{0, 0, 0, 0, 0, 1, 1, 1};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pin_rst_i = 1'b0;
    logic       chkstop_i = 1'b0;
    logic [1:0] boot_cfg_i = 2'b01;
    logic       pull_cfg_i = 1'b1;
    logic       reg_wr_i = 1'b0;
    logic [1:0] reg_addr_i = 2'd0;
    logic [7:0] reg_wdata_i = 8'd0;
    logic [7:0] reg_rdata_o;
    logic       sys_rst_o, rst_out_o;

    int checks = 0;
    int errors = 0;

    rst_sequencer #(.RST_LEN(RST_LEN)) i_rst_sequencer (
        .clk (clk), .rst_n (rst_n), .pin_rst_i (pin_rst_i),
        .chkstop_i (chkstop_i), .boot_cfg_i (boot_cfg_i),
        .pull_cfg_i (pull_cfg_i), .reg_wr_i (reg_wr_i),
        .reg_addr_i (reg_addr_i), .reg_wdata_i (reg_wdata_i),
        .reg_rdata_o (reg_rdata_o), .sys_rst_o (sys_rst_o),
        .rst_out_o (rst_out_o)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr_i = a; reg_wdata_i = d; reg_wr_i = 1'b1;
        @(negedge clk);
        reg_wr_i = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr_i = a;
        #1 d = reg_rdata_o;
    endtask

    task automatic pin_pulse(input int len);
        @(negedge clk);
        pin_rst_i = 1'b1;
        repeat (len) @(negedge clk);
        pin_rst_i = 1'b0;
    endtask

    // Wait n cycles, report whether sys_rst_o was ever high
    task automatic watch_sys(input int n, output bit seen);
        seen = 0;
        repeat (n) begin
            @(negedge clk);
            if (sys_rst_o) seen = 1;
        end
    endtask

    // Count consecutive cycles with rst_out_o high, starting now
    task automatic count_out(output int n, output bit sys_mismatch, output bit sys_any);
        n = 0; sys_mismatch = 0; sys_any = 0;
        while (rst_out_o && n < 100) begin
            if (sys_rst_o) sys_any = 1; else sys_mismatch = 1;
            n++;
            @(negedge clk);
        end
    endtask

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [7:0] d;
        int  n;
        bit  seen, mism, sany;

        // R10: power-on
        repeat (4) @(negedge clk);
        chk("R10 sys_rst in reset", int'(sys_rst_o), 1);
        chk("R10 rst_out in reset", int'(rst_out_o), 1);
        rst_n = 1'b1;
        count_out(n, mism, sany);
        chk("R10 por pulse length", n, RST_LEN);
        chk("R10 por pulse is system", int'(mism), 0);
        rd(2'd0, d);
        chk("R10 status after por", int'(d), 8'h41);
        rd(2'd2, d);
        chk("R9 boot latched at por", int'(d), 1);
        rd(2'd1, d);
        chk("R8 chk enable out of reset", int'(d), 8'h04);

        // R1 R2 R11: table of pin pulse lengths
        for (int v = 0; v < NVEC; v++) begin
            wr(2'd0, 8'h3F);
            pin_pulse(VEC_LEN[v]);
            watch_sys(50, seen);
            rd(2'd0, d);
            chk($sformatf("R1 glitch flag len %0d", VEC_LEN[v]), int'(d[5]), int'(VEC_GLT[v]));
            chk($sformatf("R2 pin flag len %0d", VEC_LEN[v]), int'(d[1]), int'(VEC_RST[v]));
            chk($sformatf("R2 reset seen len %0d", VEC_LEN[v]), int'(seen), int'(VEC_RST[v]));
        end

        // R3: valid reset clears glitch
        wr(2'd0, 8'h3F);
        pin_pulse(5);
        watch_sys(10, seen);
        pin_pulse(12);
        watch_sys(50, seen);
        rd(2'd0, d);
        chk("R3 glitch cleared by valid", int'(d[5]), 0);
        chk("R3 pin flag after valid", int'(d[1]), 1);
        // R3/R11: write-one clears glitch only
        pin_pulse(5);
        watch_sys(10, seen);
        rd(2'd0, d);
        chk("R1 glitch set again", int'(d[5]), 1);
        wr(2'd0, 8'h20);
        rd(2'd0, d);
        chk("R3 glitch cleared by write", int'(d[5]), 0);
        chk("R11 pin flag kept", int'(d[1]), 1);
        wr(2'd0, 8'h02);
        rd(2'd0, d);
        chk("R11 pin flag cleared", int'(d[5:0]), 0);

        // R4: software system reset
        wr(2'd1, 8'h05);
        count_out(n, mism, sany);
        chk("R4 sys pulse length", n, RST_LEN);
        chk("R4 sys follows out", int'(mism), 0);
        rd(2'd0, d);
        chk("R4 sws flag", int'(d[5:0]), 8'h08);

        // R5: software external reset, R9 capture at its end
        boot_cfg_i = 2'b10; pull_cfg_i = 1'b0;
        rd(2'd2, d);
        chk("R9 boot unchanged while idle", int'(d), 1);
        wr(2'd2, 8'h03);
        rd(2'd2, d);
        chk("R9 boot not writable", int'(d), 1);
        wr(2'd1, 8'h06);
        rd(2'd1, d);
        chk("R5 busy bit during pulse", int'(d), 8'h06);
        count_out(n, mism, sany);
        chk("R5 ext pulse length", n, RST_LEN - 1);
        chk("R5 no sys during ext", int'(sany), 0);
        rd(2'd1, d);
        chk("R5 busy bit after pulse", int'(d), 8'h04);
        rd(2'd0, d);
        chk("R5 swe flag", int'(d[4]), 1);
        chk("R9 pull captured", int'(d[6]), 0);
        rd(2'd2, d);
        chk("R9 boot captured", int'(d), 2);

        // R6: repeated ext request during a pulse is ignored
        wr(2'd1, 8'h06);
        repeat (5) @(negedge clk);
        wr(2'd1, 8'h06);
        count_out(n, mism, sany);
        chk("R6 ext ignores second request", n, RST_LEN - 7);
        // R6: sys request during an ext pulse is ignored
        wr(2'd0, 8'h3F);
        wr(2'd1, 8'h06);
        wr(2'd1, 8'h07);
        count_out(n, mism, sany);
        chk("R6 sys ignored during ext", int'(sany), 0);
        rd(2'd0, d);
        chk("R6 sws flag not set", int'(d[3]), 0);

        // R7: cancel
        wr(2'd1, 8'h06);
        repeat (4) @(negedge clk);
        chk("R7 out high before cancel", int'(rst_out_o), 1);
        wr(2'd1, 8'h04);
        chk("R7 out low after cancel", int'(rst_out_o), 0);

        // R8: checkstop enabled
        wr(2'd0, 8'h3F);
        @(negedge clk) chkstop_i = 1'b1;
        @(negedge clk) chkstop_i = 1'b0;
        count_out(n, mism, sany);
        chk("R8 checkstop reset length", n, RST_LEN);
        rd(2'd0, d);
        chk("R8 chk flag", int'(d[5:0]), 8'h04);
        // R8: checkstop disabled
        wr(2'd1, 8'h00);
        wr(2'd0, 8'h3F);
        @(negedge clk) chkstop_i = 1'b1;
        @(negedge clk) chkstop_i = 1'b0;
        watch_sys(30, seen);
        chk("R8 disabled no reset", int'(seen), 0);
        rd(2'd0, d);
        chk("R8 disabled no flag", int'(d[2]), 0);

        // R3/R10: power-on clears glitch and restores control
        pin_pulse(5);
        watch_sys(10, seen);
        pull_cfg_i = 1'b1;
        @(negedge clk) rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        count_out(n, mism, sany);
        rd(2'd0, d);
        chk("R3 por clears glitch", int'(d), 8'h41);
        rd(2'd1, d);
        chk("R8 chk enable restored", int'(d), 8'h04);

        summary();
    end
endmodule